// File: doc/BRIEF.md
# Toggle-Position Sensor Pulse Generator

This block drives two timing pulses for an image sensor: a gate pulse that moves charge from the photosites, and a substrate-reset pulse. A shared pixel-position counter clears on a line or field start strobe and then counts once per pixel clock. Each pulse is described by a 24-bit word that holds two 12-bit toggle positions. The output rises at whichever position the counter reaches first and falls at the other.

Each output has two pattern words, and its own select bit chooses between them. The select is captured only at the start strobe, so a pulse never changes pattern partway through a line. A common enable forces both pulses to their resting level. A common inversion bit flips the polarity of both outputs after all other processing. The outputs are registered, so each one shows the counter position from one clock earlier.

Top module: `tpg_top`

## Requirements
- R1: A high `line_start` at a clock edge sets the position counter to 0 at that edge, even if a line is already in progress.
- R2: When `line_start` is low, the counter increases by one per clock and then holds at 4095. Reset loads 4095, so the counter rests idle until the first strobe.
- R3: A pattern word holds its first toggle position in bits [11:0] and its second in bits [23:12]. Before inversion, the pulse is high for counter positions p where min ≤ p < max of the two positions, and low at all other positions, whichever of the two is larger.
- R4: If both toggle positions of the active word are equal, the pulse stays low before inversion for the whole line.
- R5: `pat_sel[0]` chooses the gate word (0 selects `gate_word0`, 1 selects `gate_word1`). `pat_sel[1]` chooses the substrate word in the same way. Each select bit is captured only when `line_start` is high. A change at any other time has no effect until the next strobe.
- R6: While `pulse_en` is low, both outputs take the value of `invert` at the next edge.
- R7: When `invert` is high, both outputs are the logical complement of the level they would otherwise have.
- R8: While `rst_n` is low, both outputs are 0.
- R9: The outputs are registered. The value after edge k reflects the counter position, `pulse_en` and `invert` as they stood just before edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Start strobe that clears the counter and captures the selects |
| pulse_en | input | 1 | Pulse generation enable |
| invert | input | 1 | Output polarity inversion for both pulses |
| pat_sel | input | 2 | Pattern select: bit 0 for the gate pulse, bit 1 for the substrate pulse |
| gate_word0 | input | 24 | Gate pattern 0 toggle positions |
| gate_word1 | input | 24 | Gate pattern 1 toggle positions |
| sub_word0 | input | 24 | Substrate pattern 0 toggle positions |
| sub_word1 | input | 24 | Substrate pattern 1 toggle positions |
| gate_out | output | 1 | Gate pulse |
| sub_out | output | 1 | Substrate-reset pulse |

## Verification
The assertions assume that the control inputs and pattern words hold known, non-X values on every clock edge after reset is released. They also assume that `line_start` is a synchronous level sampled at the edge, not an asynchronous event. The stimulus meets these assumptions by driving every input on the falling clock edge and setting all inputs before reset is released. The words may change while a line is running. Both the design and the reference model read them live, so changing them mid-line does not create a false mismatch.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int POS_W  = 12;
  localparam int WORD_W = 2 * POS_W;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [WORD_W-1:0] word_t;

  // Power-on pattern words: {second, first}
  localparam word_t GATE_DEF0 = {12'd370, 12'd80};
  localparam word_t GATE_DEF1 = {12'd780, 12'd490};
  localparam word_t SUB_DEF0  = {12'd720, 12'd540};
  localparam word_t SUB_DEF1  = {12'd860, 12'd830};

  function automatic pos_t first_pos(input word_t w);
    return w[POS_W-1:0];
  endfunction

  function automatic pos_t second_pos(input word_t w);
    return w[WORD_W-1:POS_W];
  endfunction

  // High from the earlier toggle up to, but not including, the later one
  function automatic logic in_window(input pos_t cnt, input pos_t a, input pos_t b);
    pos_t lo;
    pos_t hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return (cnt >= lo) && (cnt < hi);
  endfunction
endpackage

// File: rtl/tpg_counter.sv
module tpg_counter
  import tpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output pos_t cnt
);
  localparam pos_t CNT_MAX = '1;

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= CNT_MAX;
    else if (start)  cnt <= '0;
    else if (!at_max) cnt <= cnt + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !at_max) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && at_max) |=> (cnt == CNT_MAX)); // R2
endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
  import tpg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  pos_t  cnt,
  input  logic  sel,
  input  word_t word0,
  input  word_t word1,
  input  logic  en,
  input  logic  inv,
  output logic  pulse
);
  logic  sel_q;
  word_t word_act;
  pos_t  pos_a;
  pos_t  pos_b;
  logic  win;
  logic  level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= 1'b0;
    else if (start) sel_q <= sel;
  end

  assign word_act = sel_q ? word1 : word0;
  assign pos_a    = first_pos(word_act);
  assign pos_b    = second_pos(word_act);
  assign win      = in_window(cnt, pos_a, pos_b);
  assign level    = en & win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= inv ^ level;
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sel_q)); // R5
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pulse == $past(inv))); // R6
  AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_a == pos_b) |=> (pulse == $past(inv))); // R4
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic        pulse_en,
  input  logic        invert,
  input  logic [1:0]  pat_sel,
  input  logic [23:0] gate_word0,
  input  logic [23:0] gate_word1,
  input  logic [23:0] sub_word0,
  input  logic [23:0] sub_word1,
  output logic        gate_out,
  output logic        sub_out
);
  localparam int NCH = 2;

  pos_t  cnt;
  word_t w0 [NCH];
  word_t w1 [NCH];
  logic  outs [NCH];

  assign w0[0] = gate_word0;
  assign w1[0] = gate_word1;
  assign w0[1] = sub_word0;
  assign w1[1] = sub_word1;

  tpg_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .start (line_start),
    .cnt   (cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tpg_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .start (line_start),
      .cnt   (cnt),
      .sel   (pat_sel[c]),
      .word0 (w0[c]),
      .word1 (w1[c]),
      .en    (pulse_en),
      .inv   (invert),
      .pulse (outs[c])
    );
  end

  assign gate_out = outs[0];
  assign sub_out  = outs[1];

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (!gate_out && !sub_out)); // R8
endmodule

// File: tb/sim_tpg_top.sv
module sim_tpg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        pulse_en = 1'b1;
  logic        invert = 1'b0;
  logic [1:0]  pat_sel = 2'b00;
  logic [23:0] gate_word0 = {12'd370, 12'd80};
  logic [23:0] gate_word1 = {12'd780, 12'd490};
  logic [23:0] sub_word0  = {12'd720, 12'd540};
  logic [23:0] sub_word1  = {12'd860, 12'd830};
  logic        gate_out;
  logic        sub_out;

  int checks = 0;
  int fails  = 0;
  string tag = "R8";
  bit done = 0;

  // reference model state
  int  m_pos = 4095;
  bit  m_sel [2] = '{0, 0};
  bit  exp_g = 0;
  bit  exp_s = 0;

  always #4 clk = ~clk;

  tpg_top u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pulse_en(pulse_en),
    .invert(invert), .pat_sel(pat_sel), .gate_word0(gate_word0),
    .gate_word1(gate_word1), .sub_word0(sub_word0), .sub_word1(sub_word1),
    .gate_out(gate_out), .sub_out(sub_out)
  );

  // toggle counting: each toggle position already passed flips the level once
  function automatic bit ref_level(int n, logic [23:0] w);
    int a = int'(w[11:0]);
    int b = int'(w[23:12]);
    int t = ((n >= a) ? 1 : 0) + ((n >= b) ? 1 : 0);
    return (t == 1);
  endfunction

  task automatic check(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_g = 0; exp_s = 0; m_pos = 4095; m_sel[0] = 0; m_sel[1] = 0;
    end else begin
      exp_g = invert ^ (pulse_en & ref_level(m_pos, m_sel[0] ? gate_word1 : gate_word0));
      exp_s = invert ^ (pulse_en & ref_level(m_pos, m_sel[1] ? sub_word1 : sub_word0));
      if (line_start) begin
        m_pos = 0; m_sel[0] = pat_sel[0]; m_sel[1] = pat_sel[1];
      end else if (m_pos < 4095) m_pos++;
    end
    #2;
    if (!done) begin
      check("gate_out", gate_out, exp_g);
      check("sub_out", sub_out, exp_s);
    end
  end

  task automatic strobe_line(int n);
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R8: outputs low during reset, idle afterwards until the first strobe
    repeat (3) @(negedge clk);
    tag = "R8"; check("reset gate", gate_out, 1'b0); check("reset sub", sub_out, 1'b0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R3 R9 R2: power-on words, full line into saturation
    tag = "R3";
    strobe_line(1000);
    tag = "R2";
    repeat (3200) @(negedge clk);

    // R5: alternate pattern set
    tag = "R5"; pat_sel = 2'b11;
    strobe_line(1000);

    // R3: second position below the first, and a window ending at 4095
    tag = "R3"; pat_sel = 2'b00;
    gate_word0 = {12'd30, 12'd100};
    sub_word0  = {12'd4000, 12'd4095};
    strobe_line(4150);

    // R4: equal positions; window starting at position 0
    tag = "R4";
    gate_word0 = {12'd200, 12'd200};
    sub_word0  = {12'd0, 12'd0};
    gate_word1 = {12'd5, 12'd0};
    strobe_line(400);
    pat_sel = 2'b01;
    tag = "R9";
    strobe_line(50);

    // R5: select change mid-line must not take effect until the next strobe
    tag = "R5";
    gate_word0 = {12'd370, 12'd80}; gate_word1 = {12'd780, 12'd490};
    sub_word0 = {12'd720, 12'd540};
    pat_sel = 2'b00;
    strobe_line(100);
    pat_sel = 2'b11;
    repeat (900) @(negedge clk);

    // R6: enable toggled through a line
    tag = "R6";
    strobe_line(0);
    for (int i = 0; i < 25; i++) begin
      pulse_en = ~pulse_en;
      repeat (37) @(negedge clk);
    end
    pulse_en = 1'b1;

    // R7: inversion of both outputs, with enable gaps
    tag = "R7"; invert = 1'b1;
    strobe_line(0);
    for (int i = 0; i < 20; i++) begin
      pulse_en = (i % 3) != 0;
      repeat (45) @(negedge clk);
    end
    pulse_en = 1'b1; invert = 1'b0;

    // R1: restart in the middle of a pulse
    tag = "R1"; pat_sel = 2'b00;
    strobe_line(300);
    strobe_line(300);
    strobe_line(900);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule